// File: doc/BRIEF.md
# MI Coherence Cache Controller

This block is the coherence engine for a small private first-level cache. Each line has only two stable states, owned-and-dirty (Modified) or absent (Invalid). Any access to an absent line therefore asks the home directory for exclusive ownership, whether it is a read or a write. Processor loads, instruction fetches and stores that hit an owned line complete locally. A miss allocates the single transaction buffer, sends an ownership request and completes when the data response arrives.

The directory side feeds two inbound channels. The forward channel carries ownership requests from other caches, writeback acknowledgements and negative acknowledgements, and invalidations. The response channel carries data fills. An explicit replacement from the processor writes the line back. Until the directory acknowledges the writeback, the line's data stays in the transaction buffer, so a forwarded ownership request that crosses the writeback can still be answered. Outbound requests and data responses pass through fixed-latency delay lines, and counters record demand hits and misses.

Addresses map one to one onto lines (2^ADDR_W lines), so there is no tag or conflict logic.

Top module: `mi_l1_ctrl`

## Requirements
- R1: After reset, both counters read zero, no output valid is high, and no pop is asserted while the inputs are idle.
- R2: At most one inbound item is consumed per cycle, with strict priority: a response first, then a forward, then the processor request. A lower-priority input is not popped while a higher one is valid.
- R3: The processor request kinds are 0 load, 1 instruction fetch, 2 store and 3 replacement. A load, fetch or store to a Modified line is popped and completes in the next cycle with external flag 0. A load or fetch returns the line data; a store writes its data and returns it. The hit counter rises by one.
- R4: A load, fetch or store to an Invalid line with the buffer free is popped, and the miss counter rises by one. An outbound request with type bit 0 (ownership) carries the address and the NODE_ID requestor. If the request is popped in cycle k, the outbound request is valid in cycle k+REQ_LAT.
- R5: A response of kind 1 (data) whose address matches a pending miss does three things. It fills the line and makes it Modified; for a store miss the store's data is kept instead of the fill. It completes the access in the next cycle with external flag 1. It frees the buffer.
- R6: A forward of kind 0 (ownership) to a Modified line does three things. It sends the line data, addressed to the requestor named in the forward, valid RSP_LAT cycles after the pop. It invalidates the line. It raises an eviction notice for that address in the next cycle.
- R7: A replacement of a Modified line does three things. It captures the data in the buffer and sends a request with type bit 1 (writeback) carrying that data, REQ_LAT cycles after the pop. It invalidates the line and raises an eviction notice in the next cycle. A replacement of an Invalid line is popped and has no effect.
- R8: While a writeback is pending, a forwarded ownership request for that address is answered with the buffered data.
- R9: A forward of kind 1 (acknowledge) or kind 2 (negative acknowledge) ends a pending writeback and frees the buffer; the line stays Invalid and the next access to it misses.
- R10: A forward of kind 3 (invalidate) to a Modified line drops it and raises an eviction notice in the next cycle, without sending data.
- R11: A processor request to the address of the pending transaction is not popped. A miss or a replacement of a Modified line is not popped while the buffer is busy. Hits to other lines still complete.
- R12: A forward kind of 4 to 7, a response kind other than 1, or a data response with no matching pending miss is popped without changing state. It raises the protocol-error output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqKind | input | 2 | 0 load, 1 fetch, 2 store, 3 replacement |
| cpuReqAddr | input | ADDR_W | Line address |
| cpuReqData | input | DATA_W | Store data |
| cpuReqPop | output | 1 | Processor request consumed this cycle |
| cpuDoneValid | output | 1 | Access completed |
| cpuDoneData | output | DATA_W | Line value after the access |
| cpuDoneExternal | output | 1 | 1 when completed by a fill |
| cpuEvictValid | output | 1 | Line lost notice |
| cpuEvictAddr | output | ADDR_W | Address of the lost line |
| reqOutValid | output | 1 | Outbound request valid |
| reqOutWb | output | 1 | 0 ownership, 1 writeback |
| reqOutAddr | output | ADDR_W | Request address |
| reqOutData | output | DATA_W | Writeback data |
| reqOutRequestor | output | ID_W | This node's identifier |
| fwdValid | input | 1 | Forward present |
| fwdKind | input | 3 | 0 ownership, 1 ack, 2 nack, 3 invalidate |
| fwdAddr | input | ADDR_W | Forward address |
| fwdRequestor | input | ID_W | Node asking for ownership |
| fwdPop | output | 1 | Forward consumed this cycle |
| rspInValid | input | 1 | Inbound response present |
| rspInKind | input | 2 | 1 data |
| rspInAddr | input | ADDR_W | Response address |
| rspInData | input | DATA_W | Fill data |
| rspInPop | output | 1 | Response consumed this cycle |
| rspOutValid | output | 1 | Outbound data response valid |
| rspOutAddr | output | ADDR_W | Its address |
| rspOutData | output | DATA_W | Its data |
| rspOutDest | output | ID_W | Destination node |
| hitCount | output | CNT_W | Demand hits |
| missCount | output | CNT_W | Demand misses |
| protoErr | output | 1 | Unexpected message seen |

## Verification
On every cycle, the assertions check several properties. At most one input is popped per cycle. The hit counter moves by at most one. A miss is never counted for a valid line. An eviction notice never names a line that is still valid. A popped processor request never targets the pending address, and an accepted fill always frees the buffer. Only the bench's scenarios can show the rest. These include the exact latencies of both outbound channels, and that a forward crossing a writeback returns the buffered data rather than stale or missing data. They also cover the merge of store data over a fill, and that erroneous or no-op messages leave the line contents untouched.

// File: rtl/mi_pkg.sv
`timescale 1ns/1ps
package mi_pkg;
  // processor request kinds
  localparam logic [1:0] CPU_LOAD    = 2'd0;
  localparam logic [1:0] CPU_IFETCH  = 2'd1;
  localparam logic [1:0] CPU_STORE   = 2'd2;
  localparam logic [1:0] CPU_REPLACE = 2'd3;
  // forward channel kinds
  localparam logic [2:0] FWD_OWN     = 3'd0;
  localparam logic [2:0] FWD_WB_ACK  = 3'd1;
  localparam logic [2:0] FWD_WB_NACK = 3'd2;
  localparam logic [2:0] FWD_INVAL   = 3'd3;
  // response channel kinds
  localparam logic [1:0] RSP_DATA    = 2'd1;

  typedef enum logic [2:0] {
    TB_IDLE, TB_FILL_RD, TB_FILL_WR, TB_WB_PEND, TB_WB_LOST
  } tbe_state_e;

  typedef enum logic [1:0] {SEL_CPU, SEL_FWD, SEL_RSP} addr_sel_e;

  typedef struct packed {
    addr_sel_e addrSel;
    logic lineFill;
    logic fillFromTbe;
    logic lineWrite;
    logic lineClear;
    logic tbeCapture;
    logic tbeFromLine;
    logic reqSend;
    logic reqWb;
    logic rspSend;
    logic rspFromTbe;
    logic hitInc;
    logic missInc;
    logic doneValid;
    logic doneExt;
    logic evict;
    logic protoErr;
  } mi_strobe_t;
endpackage

// File: rtl/mi_delay_line.sv
`timescale 1ns/1ps
module mi_delay_line #(
  parameter int W   = 8,
  parameter int LAT = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic [W-1:0] inData,
  output logic         outValid,
  output logic [W-1:0] outData
);
  logic [LAT-1:0] stageVld;
  logic [W-1:0]   stageDat [LAT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageVld[0] <= 1'b0;
      stageDat[0] <= '0;
    end else begin
      stageVld[0] <= inValid;
      stageDat[0] <= inData;
    end
  end

  for (genvar i = 1; i < LAT; i++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageVld[i] <= 1'b0;
        stageDat[i] <= '0;
      end else begin
        stageVld[i] <= stageVld[i-1];
        stageDat[i] <= stageDat[i-1];
      end
    end
  end

  assign outValid = stageVld[LAT-1];
  assign outData  = stageDat[LAT-1];
endmodule

// File: rtl/mi_ctrl.sv
`timescale 1ns/1ps
module mi_ctrl import mi_pkg::*; #(
  parameter int ADDR_W = 4,
  localparam int LINES = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  input  logic [1:0]        cpuReqKind,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic              fwdValid,
  input  logic [2:0]        fwdKind,
  input  logic [ADDR_W-1:0] fwdAddr,
  input  logic              rspInValid,
  input  logic [1:0]        rspInKind,
  input  logic [ADDR_W-1:0] rspInAddr,
  input  logic [LINES-1:0]  lineValid,
  input  logic [ADDR_W-1:0] tbeAddr,
  output logic              cpuReqPop,
  output logic              fwdPop,
  output logic              rspInPop,
  output mi_strobe_t        strb
);
  tbe_state_e tbeState, tbeNext;
  logic busy, cpuMatch, fwdMatch, rspMatch, wbActive;

  assign busy     = (tbeState != TB_IDLE);
  assign cpuMatch = busy && (cpuReqAddr == tbeAddr);
  assign fwdMatch = busy && (fwdAddr == tbeAddr);
  assign rspMatch = busy && (rspInAddr == tbeAddr);
  assign wbActive = (tbeState == TB_WB_PEND) || (tbeState == TB_WB_LOST);

  always_comb begin
    strb      = '0;
    strb.addrSel = SEL_CPU;
    cpuReqPop = 1'b0;
    fwdPop    = 1'b0;
    rspInPop  = 1'b0;
    tbeNext   = tbeState;
    if (rspInValid) begin
      rspInPop     = 1'b1;
      strb.addrSel = SEL_RSP;
      if (rspInKind == RSP_DATA && rspMatch &&
          (tbeState == TB_FILL_RD || tbeState == TB_FILL_WR)) begin
        strb.lineFill    = 1'b1;
        strb.fillFromTbe = (tbeState == TB_FILL_WR);
        strb.doneValid   = 1'b1;
        strb.doneExt     = 1'b1;
        tbeNext          = TB_IDLE;
      end else begin
        strb.protoErr = 1'b1;
      end
    end else if (fwdValid) begin
      fwdPop       = 1'b1;
      strb.addrSel = SEL_FWD;
      case (fwdKind)
        FWD_OWN: begin
          if (fwdMatch) begin
            if (tbeState == TB_WB_PEND) begin
              strb.rspSend    = 1'b1;
              strb.rspFromTbe = 1'b1;
              tbeNext         = TB_WB_LOST;
            end
          end else if (lineValid[fwdAddr]) begin
            strb.rspSend   = 1'b1;
            strb.lineClear = 1'b1;
            strb.evict     = 1'b1;
          end
        end
        FWD_WB_ACK, FWD_WB_NACK: begin
          if (fwdMatch && wbActive) tbeNext = TB_IDLE;
        end
        FWD_INVAL: begin
          if (fwdMatch) begin
            if (tbeState == TB_WB_PEND) tbeNext = TB_WB_LOST;
          end else if (lineValid[fwdAddr]) begin
            strb.lineClear = 1'b1;
            strb.evict     = 1'b1;
          end
        end
        default: strb.protoErr = 1'b1;
      endcase
    end else if (cpuReqValid && !cpuMatch) begin
      if (lineValid[cpuReqAddr]) begin
        if (cpuReqKind == CPU_REPLACE) begin
          if (!busy) begin
            cpuReqPop        = 1'b1;
            strb.tbeCapture  = 1'b1;
            strb.tbeFromLine = 1'b1;
            strb.reqSend     = 1'b1;
            strb.reqWb       = 1'b1;
            strb.lineClear   = 1'b1;
            strb.evict       = 1'b1;
            tbeNext          = TB_WB_PEND;
          end
        end else begin
          cpuReqPop      = 1'b1;
          strb.hitInc    = 1'b1;
          strb.doneValid = 1'b1;
          strb.lineWrite = (cpuReqKind == CPU_STORE);
        end
      end else if (cpuReqKind == CPU_REPLACE) begin
        cpuReqPop = 1'b1;
      end else if (!busy) begin
        cpuReqPop       = 1'b1;
        strb.missInc    = 1'b1;
        strb.tbeCapture = 1'b1;
        strb.reqSend    = 1'b1;
        tbeNext = (cpuReqKind == CPU_STORE) ? TB_FILL_WR : TB_FILL_RD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) tbeState <= TB_IDLE;
    else       tbeState <= tbeNext;
  end

  // R11: the pending address is never handed to the processor side
  a_r11_no_pop_pending: assert property (@(posedge clk) disable iff (!rstN)
    cpuReqPop |-> !(tbeState != TB_IDLE && cpuReqAddr == tbeAddr));

  // R5: an accepted fill always leaves the buffer free
  a_r5_fill_frees: assert property (@(posedge clk) disable iff (!rstN)
    (rspInPop && strb.lineFill) |=> (tbeState == TB_IDLE));
endmodule

// File: rtl/mi_datapath.sv
`timescale 1ns/1ps
module mi_datapath import mi_pkg::*; #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter int REQ_LAT = 2,
  parameter int RSP_LAT = 12,
  parameter int CNT_W   = 16,
  localparam int LINES  = 1 << ADDR_W,
  localparam int REQ_W  = 1 + ADDR_W + DATA_W,
  localparam int RSP_W  = ADDR_W + DATA_W + ID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mi_strobe_t        strb,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqData,
  input  logic [ADDR_W-1:0] fwdAddr,
  input  logic [ID_W-1:0]   fwdRequestor,
  input  logic [ADDR_W-1:0] rspInAddr,
  input  logic [DATA_W-1:0] rspInData,
  output logic [LINES-1:0]  lineValid,
  output logic [ADDR_W-1:0] tbeAddr,
  output logic              cpuDoneValid,
  output logic [DATA_W-1:0] cpuDoneData,
  output logic              cpuDoneExternal,
  output logic              cpuEvictValid,
  output logic [ADDR_W-1:0] cpuEvictAddr,
  output logic              reqOutValid,
  output logic              reqOutWb,
  output logic [ADDR_W-1:0] reqOutAddr,
  output logic [DATA_W-1:0] reqOutData,
  output logic              rspOutValid,
  output logic [ADDR_W-1:0] rspOutAddr,
  output logic [DATA_W-1:0] rspOutData,
  output logic [ID_W-1:0]   rspOutDest,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic              protoErr
);
  logic [DATA_W-1:0] lineData [LINES];
  logic [DATA_W-1:0] tbeData;
  logic [ADDR_W-1:0] opAddr;
  logic [DATA_W-1:0] fillValue, newValue, lineRead;
  logic [REQ_W-1:0]  reqIn, reqOut;
  logic [RSP_W-1:0]  rspIn, rspOut;

  always_comb begin
    case (strb.addrSel)
      SEL_FWD: opAddr = fwdAddr;
      SEL_RSP: opAddr = rspInAddr;
      default: opAddr = cpuReqAddr;
    endcase
  end

  assign lineRead  = lineData[opAddr];
  assign fillValue = strb.fillFromTbe ? tbeData : rspInData;
  assign newValue  = strb.lineFill ? fillValue : cpuReqData;

  always_ff @(posedge clk) begin
    if (strb.lineFill || strb.lineWrite) lineData[opAddr] <= newValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineValid <= '0;
    end else begin
      if (strb.lineFill)  lineValid[opAddr] <= 1'b1;
      if (strb.lineClear) lineValid[opAddr] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tbeAddr <= '0;
      tbeData <= '0;
    end else if (strb.tbeCapture) begin
      tbeAddr <= opAddr;
      tbeData <= strb.tbeFromLine ? lineRead : cpuReqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuDoneValid    <= 1'b0;
      cpuDoneData     <= '0;
      cpuDoneExternal <= 1'b0;
      cpuEvictValid   <= 1'b0;
      cpuEvictAddr    <= '0;
      protoErr        <= 1'b0;
      hitCount        <= '0;
      missCount       <= '0;
    end else begin
      cpuDoneValid    <= strb.doneValid;
      cpuDoneExternal <= strb.doneExt;
      if (strb.doneValid)
        cpuDoneData <= (strb.lineFill || strb.lineWrite) ? newValue : lineRead;
      cpuEvictValid <= strb.evict;
      if (strb.evict) cpuEvictAddr <= opAddr;
      protoErr <= strb.protoErr;
      if (strb.hitInc)  hitCount  <= hitCount + 1'b1;
      if (strb.missInc) missCount <= missCount + 1'b1;
    end
  end

  assign reqIn = {strb.reqWb, opAddr, strb.reqWb ? lineRead : {DATA_W{1'b0}}};
  assign rspIn = {fwdAddr, strb.rspFromTbe ? tbeData : lineData[fwdAddr], fwdRequestor};

  mi_delay_line #(.W(REQ_W), .LAT(REQ_LAT)) uReqPipe (
    .clk(clk), .rstN(rstN), .inValid(strb.reqSend), .inData(reqIn),
    .outValid(reqOutValid), .outData(reqOut));

  mi_delay_line #(.W(RSP_W), .LAT(RSP_LAT)) uRspPipe (
    .clk(clk), .rstN(rstN), .inValid(strb.rspSend), .inData(rspIn),
    .outValid(rspOutValid), .outData(rspOut));

  assign {reqOutWb, reqOutAddr, reqOutData} = reqOut;
  assign {rspOutAddr, rspOutData, rspOutDest} = rspOut;

  // R3: the hit counter advances by at most one per cycle
  a_r3_hit_step: assert property (@(posedge clk) disable iff (!rstN)
    (hitCount == $past(hitCount)) || (hitCount == $past(hitCount) + 1'b1));

  // R4: a miss is only ever counted against an invalid line
  a_r4_miss_on_invalid: assert property (@(posedge clk) disable iff (!rstN)
    strb.missInc |-> !lineValid[opAddr]);

  // R6: an eviction notice never names a line still held
  a_r6_evict_line_gone: assert property (@(posedge clk) disable iff (!rstN)
    cpuEvictValid |-> !lineValid[cpuEvictAddr]);
endmodule

// File: rtl/mi_l1_ctrl.sv
`timescale 1ns/1ps
module mi_l1_ctrl import mi_pkg::*; #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int ID_W    = 4,
  parameter logic [ID_W-1:0] NODE_ID = '0,
  parameter int REQ_LAT = 2,
  parameter int RSP_LAT = 12,
  parameter int CNT_W   = 16,
  localparam int LINES  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReqValid,
  input  logic [1:0]        cpuReqKind,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqData,
  output logic              cpuReqPop,
  output logic              cpuDoneValid,
  output logic [DATA_W-1:0] cpuDoneData,
  output logic              cpuDoneExternal,
  output logic              cpuEvictValid,
  output logic [ADDR_W-1:0] cpuEvictAddr,
  output logic              reqOutValid,
  output logic              reqOutWb,
  output logic [ADDR_W-1:0] reqOutAddr,
  output logic [DATA_W-1:0] reqOutData,
  output logic [ID_W-1:0]   reqOutRequestor,
  input  logic              fwdValid,
  input  logic [2:0]        fwdKind,
  input  logic [ADDR_W-1:0] fwdAddr,
  input  logic [ID_W-1:0]   fwdRequestor,
  output logic              fwdPop,
  input  logic              rspInValid,
  input  logic [1:0]        rspInKind,
  input  logic [ADDR_W-1:0] rspInAddr,
  input  logic [DATA_W-1:0] rspInData,
  output logic              rspInPop,
  output logic              rspOutValid,
  output logic [ADDR_W-1:0] rspOutAddr,
  output logic [DATA_W-1:0] rspOutData,
  output logic [ID_W-1:0]   rspOutDest,
  output logic [CNT_W-1:0]  hitCount,
  output logic [CNT_W-1:0]  missCount,
  output logic              protoErr
);
  mi_strobe_t        strb;
  logic [LINES-1:0]  lineValid;
  logic [ADDR_W-1:0] tbeAddr;

  assign reqOutRequestor = NODE_ID;

  mi_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqKind(cpuReqKind), .cpuReqAddr(cpuReqAddr),
    .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdAddr(fwdAddr),
    .rspInValid(rspInValid), .rspInKind(rspInKind), .rspInAddr(rspInAddr),
    .lineValid(lineValid), .tbeAddr(tbeAddr),
    .cpuReqPop(cpuReqPop), .fwdPop(fwdPop), .rspInPop(rspInPop), .strb(strb));

  mi_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .REQ_LAT(REQ_LAT),
                .RSP_LAT(RSP_LAT), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cpuReqAddr(cpuReqAddr), .cpuReqData(cpuReqData),
    .fwdAddr(fwdAddr), .fwdRequestor(fwdRequestor),
    .rspInAddr(rspInAddr), .rspInData(rspInData),
    .lineValid(lineValid), .tbeAddr(tbeAddr),
    .cpuDoneValid(cpuDoneValid), .cpuDoneData(cpuDoneData),
    .cpuDoneExternal(cpuDoneExternal),
    .cpuEvictValid(cpuEvictValid), .cpuEvictAddr(cpuEvictAddr),
    .reqOutValid(reqOutValid), .reqOutWb(reqOutWb), .reqOutAddr(reqOutAddr),
    .reqOutData(reqOutData),
    .rspOutValid(rspOutValid), .rspOutAddr(rspOutAddr), .rspOutData(rspOutData),
    .rspOutDest(rspOutDest),
    .hitCount(hitCount), .missCount(missCount), .protoErr(protoErr));

  // R2: never more than one inbound item consumed in a cycle
  a_r2_single_pop: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cpuReqPop, fwdPop, rspInPop}));
endmodule

// File: tb/mi_l1_ctrl_test.sv
`timescale 1ns/1ps
module mi_l1_ctrl_test;
  localparam int A = 3, D = 8, IDW = 4, RQL = 2, RSL = 12, CW = 16;
  localparam int N = 1 << A;
  localparam logic [IDW-1:0] MYID = 4'd9;

  logic clk = 1'b0, rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic cpuReqValid = 0; logic [1:0] cpuReqKind = 0; logic [A-1:0] cpuReqAddr = 0;
  logic [D-1:0] cpuReqData = 0;
  logic fwdValid = 0; logic [2:0] fwdKind = 0; logic [A-1:0] fwdAddr = 0;
  logic [IDW-1:0] fwdRequestor = 0;
  logic rspInValid = 0; logic [1:0] rspInKind = 0; logic [A-1:0] rspInAddr = 0;
  logic [D-1:0] rspInData = 0;
  logic cpuReqPop, cpuDoneValid, cpuDoneExternal, cpuEvictValid, reqOutValid, reqOutWb;
  logic fwdPop, rspInPop, rspOutValid, protoErr;
  logic [D-1:0] cpuDoneData, reqOutData, rspOutData;
  logic [A-1:0] cpuEvictAddr, reqOutAddr, rspOutAddr;
  logic [IDW-1:0] reqOutRequestor, rspOutDest;
  logic [CW-1:0] hitCount, missCount;

  mi_l1_ctrl #(.ADDR_W(A), .DATA_W(D), .ID_W(IDW), .NODE_ID(MYID), .REQ_LAT(RQL),
               .RSP_LAT(RSL), .CNT_W(CW)) uut (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int reqCyc = -1, rspCyc = -1, doneCyc = -1, evCyc = -1, errCyc = -1;
  logic reqWbS; logic [A-1:0] reqAddrS, rspAddrS, evAddrS; logic [D-1:0] reqDataS, rspDataS, doneDataS;
  logic [IDW-1:0] rspDestS; logic doneExtS;
  always @(negedge clk) begin
    if (reqOutValid) begin reqCyc = cyc; reqWbS = reqOutWb; reqAddrS = reqOutAddr; reqDataS = reqOutData; end
    if (rspOutValid) begin rspCyc = cyc; rspAddrS = rspOutAddr; rspDataS = rspOutData; rspDestS = rspOutDest; end
    if (cpuDoneValid) begin doneCyc = cyc; doneDataS = cpuDoneData; doneExtS = cpuDoneExternal; end
    if (cpuEvictValid) begin evCyc = cyc; evAddrS = cpuEvictAddr; end
    if (protoErr) errCyc = cyc;
  end

  int nChecks = 0, nFail = 0;
  int hitExp = 0, missExp = 0;
  logic [D-1:0] lineExp [N];

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpuOp(input logic [1:0] k, input int a, input int d, output bit popped, output int acc);
    @(negedge clk);
    cpuReqValid = 1; cpuReqKind = k; cpuReqAddr = a[A-1:0]; cpuReqData = d[D-1:0];
    #1; popped = cpuReqPop; acc = cyc;
    @(negedge clk); cpuReqValid = 0;
  endtask

  task automatic fwdOp(input logic [2:0] k, input int a, input int who, output bit popped, output int acc);
    @(negedge clk);
    fwdValid = 1; fwdKind = k; fwdAddr = a[A-1:0]; fwdRequestor = who[IDW-1:0];
    #1; popped = fwdPop; acc = cyc;
    @(negedge clk); fwdValid = 0;
  endtask

  task automatic rspOp(input logic [1:0] k, input int a, input int d, output bit popped, output int acc);
    @(negedge clk);
    rspInValid = 1; rspInKind = k; rspInAddr = a[A-1:0]; rspInData = d[D-1:0];
    #1; popped = rspInPop; acc = cyc;
    @(negedge clk); rspInValid = 0;
  endtask

  // load hit returning the expected value
  task automatic loadHit(input int a, input string tag);
    bit p; int acc;
    cpuOp(2'd0, a, 0, p, acc); hitExp++;
    idle(1);
    chk({tag, " hit pop"}, p, 1);
    chk({tag, " hit data"}, doneDataS, lineExp[a]);
    chk({tag, " hit cycle"}, doneCyc, acc + 1);
  endtask

  // complete a miss on address a with fill value v, store value sv if isStore
  task automatic missFill(input logic [1:0] k, input int a, input int v, input int sv, input string tag);
    bit p; int acc;
    cpuOp(k, a, sv, p, acc); missExp++;
    idle(RQL + 1);
    chk({tag, " R4 miss pop"}, p, 1);
    chk({tag, " R4 req cycle"}, reqCyc, acc + RQL);
    chk({tag, " R4 req type"}, reqWbS, 0);
    chk({tag, " R4 req addr"}, reqAddrS, a);
    chk({tag, " R4 miss count"}, missCount, missExp);
    rspOp(2'd1, a, v, p, acc);
    idle(1);
    lineExp[a] = (k == 2'd2) ? sv[D-1:0] : v[D-1:0];
    chk({tag, " R5 fill pop"}, p, 1);
    chk({tag, " R5 done cycle"}, doneCyc, acc + 1);
    chk({tag, " R5 done data"}, doneDataS, lineExp[a]);
    chk({tag, " R5 external"}, doneExtS, 1);
  endtask

  initial begin
    bit p; int acc, saved, saved2;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 hits", hitCount, 0); chk("R1 misses", missCount, 0);
    chk("R1 done", cpuDoneValid, 0); chk("R1 req", reqOutValid, 0);
    chk("R1 rsp", rspOutValid, 0); chk("R1 pops", {cpuReqPop, fwdPop, rspInPop}, 0);
    chk("R1 requestor id", reqOutRequestor, MYID);
    rstN = 1;
    idle(2);

    // sweep: miss every line, with stall and hit-under-miss checks
    for (int a = 0; a < N; a++) begin
      cpuOp((a % 2) ? 2'd1 : 2'd0, a, 0, p, acc); missExp++;
      idle(RQL + 1);
      chk("R4 sweep pop", p, 1);
      chk("R4 sweep req cycle", reqCyc, acc + RQL);
      chk("R4 sweep req addr", reqAddrS, a);
      chk("R4 sweep req type", reqWbS, 0);
      chk("R4 sweep count", missCount, missExp);
      cpuOp(2'd0, a, 0, p, acc);
      chk("R11 same addr stalls", p, 0);
      if (a < N - 1) begin
        cpuOp(2'd2, a + 1, 3, p, acc);
        chk("R11 second miss stalls", p, 0);
      end
      if (a > 0) loadHit(a - 1, "R11 hit under miss");
      rspOp(2'd1, a, a * 29 + 7, p, acc);
      idle(1);
      lineExp[a] = 8'(a * 29 + 7);
      chk("R5 sweep pop", p, 1);
      chk("R5 sweep done cycle", doneCyc, acc + 1);
      chk("R5 sweep data", doneDataS, lineExp[a]);
      chk("R5 sweep external", doneExtS, 1);
    end

    // R3: hits across all lines, load, fetch and store
    for (int a = 0; a < N; a++) begin
      cpuOp(2'd1, a, 0, p, acc); hitExp++;
      idle(1);
      chk("R3 fetch data", doneDataS, lineExp[a]);
      chk("R3 fetch local", doneExtS, 0);
      cpuOp(2'd2, a, a * 13 + 100, p, acc); hitExp++;
      lineExp[a] = 8'(a * 13 + 100);
      idle(1);
      chk("R3 store pop", p, 1);
      chk("R3 store data", doneDataS, lineExp[a]);
      loadHit(a, "R3 readback");
      chk("R3 hit count", hitCount, hitExp);
    end

    // R6: forwarded ownership on a held line
    fwdOp(3'd0, 0, 5, p, acc);
    idle(RSL + 1);
    chk("R6 pop", p, 1);
    chk("R6 rsp cycle", rspCyc, acc + RSL);
    chk("R6 rsp data", rspDataS, lineExp[0]);
    chk("R6 rsp dest", rspDestS, 5);
    chk("R6 rsp addr", rspAddrS, 0);
    chk("R6 evict cycle", evCyc, acc + 1);
    chk("R6 evict addr", evAddrS, 0);
    // R5: store miss keeps store data over fill
    missFill(2'd2, 0, 8'h11, 8'h77, "R5 store miss");
    loadHit(0, "R5 merged");

    // R7 and R8: replacement, forward crossing writeback, negative ack
    saved = lineExp[1];
    cpuOp(2'd3, 1, 0, p, acc);
    idle(RQL + 1);
    chk("R7 pop", p, 1);
    chk("R7 wb cycle", reqCyc, acc + RQL);
    chk("R7 wb type", reqWbS, 1);
    chk("R7 wb data", reqDataS, saved);
    chk("R7 evict cycle", evCyc, acc + 1);
    chk("R7 evict addr", evAddrS, 1);
    cpuOp(2'd0, 1, 0, p, acc);
    chk("R11 writeback addr stalls", p, 0);
    cpuOp(2'd3, 2, 0, p, acc);
    chk("R11 replace while busy stalls", p, 0);
    loadHit(2, "R11 hit during writeback");
    fwdOp(3'd0, 1, 6, p, acc);
    idle(RSL + 1);
    chk("R8 rsp cycle", rspCyc, acc + RSL);
    chk("R8 rsp from buffer", rspDataS, saved);
    chk("R8 rsp dest", rspDestS, 6);
    fwdOp(3'd2, 1, 0, p, acc);
    chk("R9 nack pop", p, 1);
    missFill(2'd0, 1, 8'h42, 0, "R9 after nack");

    // R9: acknowledge path
    cpuOp(2'd3, 3, 0, p, acc);
    fwdOp(3'd1, 3, 0, p, acc);
    chk("R9 ack pop", p, 1);
    missFill(2'd1, 3, 8'h5c, 0, "R9 after ack");

    // R10: invalidate held line, no data sent
    saved = rspCyc; saved2 = reqCyc;
    fwdOp(3'd3, 4, 0, p, acc);
    idle(RSL + 1);
    chk("R10 pop", p, 1);
    chk("R10 evict cycle", evCyc, acc + 1);
    chk("R10 evict addr", evAddrS, 4);
    chk("R10 no data", rspCyc, saved);
    // R7: replacement of invalid line has no effect
    saved = evCyc;
    cpuOp(2'd3, 4, 0, p, acc);
    idle(RQL + 1);
    chk("R7 invalid replace pop", p, 1);
    chk("R7 invalid replace no req", reqCyc, saved2);
    chk("R7 invalid replace no evict", evCyc, saved);
    missFill(2'd0, 4, 8'h99, 0, "R7 line still invalid");

    // R12: protocol errors
    fwdOp(3'd5, 2, 0, p, acc);
    idle(1);
    chk("R12 bad fwd pop", p, 1);
    chk("R12 bad fwd err", errCyc, acc + 1);
    rspOp(2'd2, 5, 0, p, acc);
    idle(1);
    chk("R12 bad rsp err", errCyc, acc + 1);
    rspOp(2'd1, 5, 8'hee, p, acc);
    idle(1);
    chk("R12 unmatched data err", errCyc, acc + 1);
    loadHit(5, "R12 line untouched");
    loadHit(2, "R12 line untouched after bad fwd");

    // R2: priority among simultaneous inputs
    @(negedge clk);
    rspInValid = 1; rspInKind = 2'd0; rspInAddr = 0;
    fwdValid = 1; fwdKind = 3'd6; fwdAddr = 0;
    cpuReqValid = 1; cpuReqKind = 2'd0; cpuReqAddr = 3'd6;
    #1;
    chk("R2 rsp first", {rspInPop, fwdPop, cpuReqPop}, 3'b100);
    @(negedge clk); rspInValid = 0; #1;
    chk("R2 fwd second", {rspInPop, fwdPop, cpuReqPop}, 3'b010);
    @(negedge clk); fwdValid = 0; #1; acc = cyc;
    chk("R2 cpu last", {rspInPop, fwdPop, cpuReqPop}, 3'b001);
    hitExp++;
    @(negedge clk); cpuReqValid = 0;
    idle(1);
    chk("R2 cpu done data", doneDataS, lineExp[6]);
    chk("R3 final hits", hitCount, hitExp);
    chk("R4 final misses", missCount, missExp);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule